// File: doc/BRIEF.md
# Soft-Start and Soft-Stop Fault Sequencer

This block sequences the two start-up ramps of an isolated full-bridge power stage controller: the primary duty-cycle limit ramp and the synchronous-rectifier ramp. Both ramps are digital counters. The block waits until the enable, supply and reference status inputs are all good. It then charges the primary ramp. The rectifier ramp is released only after the primary ramp has passed a gate level and the regulation loop has taken control. Rectifier switching is flagged once the rectifier ramp clears an offset level.

On shutdown the block picks one of two paths. A loss of enable while bias is still present, or a hiccup request from the current-limit logic, starts a graded soft-stop. In a soft-stop the rectifier ramp is wound down at three or six times the charge rate, and both ramps are cleared once it reaches the offset level. Overvoltage, bias undervoltage and thermal faults cause a hard-stop instead: the output enable drops in the same cycle and both ramps clear at the next clock. A strap input turns every stop into a hard-stop. Threshold levels and discharge rates are parameters given in counter units.

Top module: `ss_seq_top`

## Requirements
- R1: While `rst` is high, and while any of `en_ok`, `vcc_ok`, `ref_ok` is low, `ss_ramp` and `sr_ramp` read 0 and `drv_en` is 0.
- R2: One clock after the start conditions are first all met, `drv_en` is 1 and `ss_ramp` is 0. From then on `ss_ramp` rises by 1 per clock and saturates at 2^RAMP_W-1.
- R3: `sr_ramp` stays 0 until a clock edge samples `ss_ramp` > SS_GATE with `loop_ctl` high. At the following edge it starts rising by 1 per clock, and it saturates at full scale.
- R4: `sr_go` is 1 exactly when `drv_en` is 1 and `sr_ramp` > SR_OFS.
- R5: When `en_ok` falls while running (with `hard_only` 0 and no hard fault), the first clock holds both ramps. After that `sr_ramp` falls by STBY_RATE (3) per clock, without going below 0. `ss_ramp` holds and `drv_en` stays 1.
- R6: A `hic_req` while running gives the same soft-stop as R5, but `sr_ramp` falls by HIC_RATE (6) per clock.
- R7: During a soft-stop, the first clock edge that samples `sr_ramp` <= SR_OFS clears both ramps and drops `drv_en`.
- R8: When `ovp_flt`, `therm_flt`, a low `vcc_ok` or a low `ref_ok` occurs, `drv_en` goes to 0 combinationally, and both ramps are 0 after the next clock edge.
- R9: With `hard_only` high, a fall of `en_ok` or a `hic_req` acts as a hard-stop (R8). `hard_only` alone has no effect on a running sequence.
- R10: After a thermal fault clears, the full start-up order of R2 and R3 runs again from zero.
- R11: If a hard cause and a soft cause arrive in the same cycle, the hard-stop wins.
- R12: A start is blocked while `hic_req`, `ovp_flt` or `therm_flt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_ok | input | 1 | Enable level above standby threshold |
| vcc_ok | input | 1 | Supply above its undervoltage threshold |
| ref_ok | input | 1 | Reference above its undervoltage threshold |
| ovp_flt | input | 1 | Overvoltage/overtemperature comparator tripped |
| therm_flt | input | 1 | Internal thermal limit |
| hic_req | input | 1 | Hiccup restart request from current-limit logic |
| hard_only | input | 1 | Strap: treat every stop as a hard-stop |
| loop_ctl | input | 1 | Feedback loop has control of the duty cycle |
| ss_ramp | output | RAMP_W | Primary soft-start ramp value |
| sr_ramp | output | RAMP_W | Rectifier soft-start ramp value |
| drv_en | output | 1 | Output drivers enabled |
| sr_go | output | 1 | Rectifier soft-start active |

## Verification
A wrong internal state shows up at the ports within one or two clocks. A rectifier-arm flag that is stuck or set too early makes `sr_ramp` leave zero one edge after the wrong sample, so the bench checks the edge on either side of the gate level. A latched discharge rate that is wrong shows up as the step size on the second clock of a soft-stop. A sequencer state that fails to return to idle leaves `drv_en` high or the ramps non-zero at the edge where the clear is due. A hard cause that is missing from the classification leaves `drv_en` high in the same cycle as the fault.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SOFT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_STBY = 2'd1,
        CAUSE_HIC  = 2'd2,
        CAUSE_HARD = 2'd3
    } stop_cause_e;

    typedef struct packed {
        logic clr;
        logic inc;
        logic dec;
    } ramp_cmd_t;

    localparam int NUM_RAMPS = 2;
    localparam int IDX_SS    = 0;
    localparam int IDX_SR    = 1;

    function automatic logic is_soft(stop_cause_e c);
        return (c == CAUSE_STBY) || (c == CAUSE_HIC);
    endfunction

endpackage

// File: rtl/ss_fault_arb.sv
module ss_fault_arb
    import ss_seq_pkg::*;
(
    input  logic        en_ok,
    input  logic        vcc_ok,
    input  logic        ref_ok,
    input  logic        ovp_flt,
    input  logic        therm_flt,
    input  logic        hic_req,
    input  logic        hard_only,
    output stop_cause_e cause,
    output logic        start_ok
);
    logic bias_bad;
    logic soft_any;

    always_comb begin
        bias_bad = !vcc_ok || !ref_ok;
        soft_any = !en_ok || hic_req;
        start_ok = en_ok && vcc_ok && ref_ok && !ovp_flt && !therm_flt && !hic_req;
        // hard causes outrank soft causes; the strap promotes soft ones
        if (ovp_flt || therm_flt || bias_bad || (hard_only && soft_any))
            cause = CAUSE_HARD;
        else if (hic_req)
            cause = CAUSE_HIC;
        else if (!en_ok)
            cause = CAUSE_STBY;
        else
            cause = CAUSE_NONE;
    end

    always_comb begin
        if (start_ok) begin
            AST_START_NOT_HARD: assert (cause == CAUSE_NONE); // R12
        end
    end

endmodule

// File: rtl/ss_ramp_ctr.sv
module ss_ramp_ctr
    import ss_seq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  ramp_cmd_t    cmd,
    input  logic [W-1:0] dec_amt,
    output logic [W-1:0] val
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic [W-1:0] val_q;
    logic [W-1:0] val_d;

    always_comb begin
        val_d = val_q;
        if (cmd.clr)
            val_d = '0;
        else if (cmd.inc)
            val_d = (val_q == FULL) ? FULL : val_q + 1'b1;
        else if (cmd.dec)
            val_d = (val_q >= dec_amt) ? val_q - dec_amt : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) val_q <= '0;
        else     val_q <= val_d;
    end

    assign val = val_q;

    AST_RAMP_SAT_HI: assert property (@(posedge clk) disable iff (rst)
        (!cmd.clr && cmd.inc && val_q == FULL) |=> (val_q == FULL)); // R2
    AST_RAMP_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!cmd.clr && !cmd.inc && cmd.dec && val_q < dec_amt) |=> (val_q == '0)); // R5
    AST_RAMP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cmd.clr |=> (val_q == '0)); // R8

endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
    import ss_seq_pkg::*;
#(
    parameter int W         = 8,
    parameter int SS_GATE   = 80,
    parameter int SR_OFS    = 40,
    parameter int STBY_RATE = 3,
    parameter int HIC_RATE  = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_ok,
    input  stop_cause_e  cause,
    input  logic         loop_ctl,
    input  logic [W-1:0] ss_val,
    input  logic [W-1:0] sr_val,
    output ramp_cmd_t    ss_cmd,
    output ramp_cmd_t    sr_cmd,
    output logic [W-1:0] dec_amt,
    output logic         drv_en
);
    localparam logic [W-1:0] GATE_V = W'(SS_GATE);
    localparam logic [W-1:0] OFS_V  = W'(SR_OFS);
    localparam logic [W-1:0] STBY_V = W'(STBY_RATE);
    localparam logic [W-1:0] HIC_V  = W'(HIC_RATE);

    seq_state_e   state_q, state_d;
    logic         armed_q, armed_d;
    logic [W-1:0] rate_q, rate_d;
    logic         hard;
    logic         soft_done;

    always_comb begin
        hard      = (cause == CAUSE_HARD);
        soft_done = (state_q == ST_SOFT) && (sr_val <= OFS_V);
        state_d   = state_q;
        armed_d   = armed_q;
        rate_d    = rate_q;
        if (hard) begin
            state_d = ST_IDLE;
            armed_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    armed_d = 1'b0;
                    if (start_ok) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (is_soft(cause)) begin
                        state_d = ST_SOFT;
                        rate_d  = (cause == CAUSE_HIC) ? HIC_V : STBY_V;
                    end else if (ss_val > GATE_V && loop_ctl) begin
                        armed_d = 1'b1;
                    end
                end
                ST_SOFT: begin
                    if (soft_done) begin
                        state_d = ST_IDLE;
                        armed_d = 1'b0;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ss_cmd.clr = hard || (state_q == ST_IDLE) || soft_done;
        ss_cmd.inc = (state_q == ST_RUN) && (cause == CAUSE_NONE);
        ss_cmd.dec = 1'b0;
        sr_cmd.clr = ss_cmd.clr;
        sr_cmd.inc = (state_q == ST_RUN) && armed_q && (cause == CAUSE_NONE);
        sr_cmd.dec = (state_q == ST_SOFT) && !soft_done && !hard;
        dec_amt    = rate_q;
        drv_en     = (state_q != ST_IDLE) && !hard;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            armed_q <= 1'b0;
            rate_q  <= STBY_V;
        end else begin
            state_q <= state_d;
            armed_q <= armed_d;
            rate_q  <= rate_d;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (ss_val == '0 && sr_val == '0)); // R1
    AST_SR_HELD_UNARMED: assert property (@(posedge clk) disable iff (rst)
        !armed_q |-> (sr_val == '0)); // R3
    AST_SOFT_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SOFT && sr_val > OFS_V && !hard) |=>
        (sr_val == (($past(sr_val) >= $past(rate_q)) ? $past(sr_val) - $past(rate_q) : '0))); // R5
    AST_SOFT_HOLDS_SS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SOFT && sr_val > OFS_V && !hard) |=> $stable(ss_val)); // R5
    AST_SOFT_END_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SOFT && sr_val <= OFS_V) |=> (ss_val == '0 && sr_val == '0)); // R7
    AST_HARD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        hard |=> (ss_val == '0 && sr_val == '0 && state_q == ST_IDLE)); // R8

endmodule

// File: rtl/ss_seq_top.sv
module ss_seq_top
    import ss_seq_pkg::*;
#(
    parameter int RAMP_W    = 8,
    parameter int SS_GATE   = 80,
    parameter int SR_OFS    = 40,
    parameter int STBY_RATE = 3,
    parameter int HIC_RATE  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_ok,
    input  logic              vcc_ok,
    input  logic              ref_ok,
    input  logic              ovp_flt,
    input  logic              therm_flt,
    input  logic              hic_req,
    input  logic              hard_only,
    input  logic              loop_ctl,
    output logic [RAMP_W-1:0] ss_ramp,
    output logic [RAMP_W-1:0] sr_ramp,
    output logic              drv_en,
    output logic              sr_go
);
    localparam logic [RAMP_W-1:0] OFS_V = RAMP_W'(SR_OFS);

    stop_cause_e       cause;
    logic              start_ok;
    ramp_cmd_t         cmd   [NUM_RAMPS];
    logic [RAMP_W-1:0] rval  [NUM_RAMPS];
    logic [RAMP_W-1:0] dec_amt;

    ss_fault_arb u_arb (
        .en_ok     (en_ok),
        .vcc_ok    (vcc_ok),
        .ref_ok    (ref_ok),
        .ovp_flt   (ovp_flt),
        .therm_flt (therm_flt),
        .hic_req   (hic_req),
        .hard_only (hard_only),
        .cause     (cause),
        .start_ok  (start_ok)
    );

    ss_seq_fsm #(
        .W         (RAMP_W),
        .SS_GATE   (SS_GATE),
        .SR_OFS    (SR_OFS),
        .STBY_RATE (STBY_RATE),
        .HIC_RATE  (HIC_RATE)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_ok (start_ok),
        .cause    (cause),
        .loop_ctl (loop_ctl),
        .ss_val   (rval[IDX_SS]),
        .sr_val   (rval[IDX_SR]),
        .ss_cmd   (cmd[IDX_SS]),
        .sr_cmd   (cmd[IDX_SR]),
        .dec_amt  (dec_amt),
        .drv_en   (drv_en)
    );

    for (genvar g = 0; g < NUM_RAMPS; g++) begin : g_ramp
        ss_ramp_ctr #(.W(RAMP_W)) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .cmd     (cmd[g]),
            .dec_amt (dec_amt),
            .val     (rval[g])
        );
    end

    assign ss_ramp = rval[IDX_SS];
    assign sr_ramp = rval[IDX_SR];
    assign sr_go   = drv_en && (rval[IDX_SR] > OFS_V);

    AST_NO_DRIVE_IN_RESET: assert property (@(posedge clk)
        rst |=> (ss_ramp == '0 && sr_ramp == '0)); // R1
    AST_SS_STEP: assert property (@(posedge clk) disable iff (rst)
        (drv_en && ss_ramp != '0 && !sr_go && $stable(ss_ramp)) |-> (ss_ramp == {RAMP_W{1'b1}} || !en_ok || hic_req)); // R2

endmodule

// File: tb/sim_ss_seq_top.sv
module sim_ss_seq_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       en_ok, vcc_ok, ref_ok, ovp_flt, therm_flt, hic_req, hard_only, loop_ctl;
    logic [7:0] ss_ramp, sr_ramp;
    logic       drv_en, sr_go;

    int nchk  = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    ss_seq_top u0 (
        .clk(clk), .rst(rst), .en_ok(en_ok), .vcc_ok(vcc_ok), .ref_ok(ref_ok),
        .ovp_flt(ovp_flt), .therm_flt(therm_flt), .hic_req(hic_req),
        .hard_only(hard_only), .loop_ctl(loop_ctl),
        .ss_ramp(ss_ramp), .sr_ramp(sr_ramp), .drv_en(drv_en), .sr_go(sr_go)
    );

    // start-up walk with loop_ctl high: edges to wait, ss, sr, sr_go
    localparam int NROW = 8;
    localparam int TBL [NROW][4] = '{
        '{1,   0,   0,   0},
        '{10,  10,  0,   0},
        '{72,  82,  0,   0},
        '{1,   83,  1,   0},
        '{39,  122, 40,  0},
        '{1,   123, 41,  1},
        '{176, 255, 217, 1},
        '{100, 255, 255, 1}
    };

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic walk_startup(input string tag);
        for (int i = 0; i < NROW; i++) begin
            edges(TBL[i][0]);
            chk({tag, " R2 ss"}, ss_ramp, TBL[i][1]);
            chk({tag, " R3 sr"}, sr_ramp, TBL[i][2]);
            chk({tag, " R4 go"}, sr_go,   TBL[i][3]);
            chk({tag, " R2 drv"}, drv_en, 1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        rst = 1; en_ok = 0; vcc_ok = 1; ref_ok = 1; ovp_flt = 0; therm_flt = 0;
        hic_req = 0; hard_only = 0; loop_ctl = 0;
        @(negedge clk);
        edges(3);
        chk("R1 reset ss", ss_ramp, 0);
        chk("R1 reset drv", drv_en, 0);
        rst = 0;
        edges(5);
        chk("R1 no enable ss", ss_ramp, 0);
        chk("R1 no enable drv", drv_en, 0);
        en_ok = 1; vcc_ok = 0;
        edges(5);
        chk("R1 vcc low drv", drv_en, 0);
        chk("R1 vcc low ss", ss_ramp, 0);

        // loop not in control: rectifier ramp must stay at zero
        vcc_ok = 1;
        edges(300);
        chk("R2 ss saturates", ss_ramp, 255);
        chk("R3 sr held without loop", sr_ramp, 0);
        chk("R4 go low", sr_go, 0);
        loop_ctl = 1;
        edges(1);
        chk("R3 arm edge sr", sr_ramp, 0);
        edges(40);
        chk("R4 sr at offset", sr_ramp, 40);
        chk("R4 go at offset", sr_go, 0);
        edges(1);
        chk("R4 sr above offset", sr_ramp, 41);
        chk("R4 go above offset", sr_go, 1);
        edges(300);
        chk("R3 sr saturates", sr_ramp, 255);

        // standby soft-stop
        en_ok = 0;
        edges(1);
        chk("R5 hold sr", sr_ramp, 255);
        chk("R5 drv kept", drv_en, 1);
        edges(1);
        chk("R5 step1", sr_ramp, 252);
        edges(1);
        chk("R5 step2", sr_ramp, 249);
        edges(70);
        chk("R5 last step", sr_ramp, 39);
        chk("R5 ss held", ss_ramp, 255);
        chk("R5 drv still", drv_en, 1);
        edges(1);
        chk("R7 ss cleared", ss_ramp, 0);
        chk("R7 sr cleared", sr_ramp, 0);
        chk("R7 drv low", drv_en, 0);
        edges(5);
        chk("R1 standby idle", ss_ramp, 0);

        en_ok = 1;
        walk_startup("first");

        // hiccup soft-stop
        hic_req = 1;
        edges(1);
        chk("R6 hold sr", sr_ramp, 255);
        edges(1);
        chk("R6 step1", sr_ramp, 249);
        edges(1);
        chk("R6 step2", sr_ramp, 243);
        edges(34);
        chk("R6 last step", sr_ramp, 39);
        chk("R6 drv kept", drv_en, 1);
        edges(1);
        chk("R7 hic clear sr", sr_ramp, 0);
        chk("R7 hic clear drv", drv_en, 0);
        edges(5);
        chk("R12 hic blocks start", drv_en, 0);
        chk("R12 hic blocks ss", ss_ramp, 0);
        hic_req = 0;
        edges(400);
        chk("R3 rerun sr", sr_ramp, 255);

        // overvoltage hard-stop
        ovp_flt = 1;
        #1;
        chk("R8 ovp drv immediate", drv_en, 0);
        edges(1);
        chk("R8 ovp ss", ss_ramp, 0);
        chk("R8 ovp sr", sr_ramp, 0);
        edges(5);
        chk("R12 ovp blocks start", drv_en, 0);
        ovp_flt = 0;
        edges(400);

        // thermal fault then full restart
        therm_flt = 1;
        #1;
        chk("R8 therm drv", drv_en, 0);
        edges(3);
        chk("R8 therm sr", sr_ramp, 0);
        therm_flt = 0;
        walk_startup("thermal R10");

        // strap forces hard stops
        hard_only = 1;
        edges(2);
        chk("R9 strap alone drv", drv_en, 1);
        chk("R9 strap alone ss", ss_ramp, 255);
        en_ok = 0;
        #1;
        chk("R9 standby hard drv", drv_en, 0);
        edges(1);
        chk("R9 standby hard sr", sr_ramp, 0);
        en_ok = 1;
        edges(400);
        hic_req = 1;
        #1;
        chk("R9 hic hard drv", drv_en, 0);
        edges(1);
        chk("R9 hic hard sr", sr_ramp, 0);
        hic_req = 0; hard_only = 0;
        edges(400);

        // simultaneous soft and hard causes
        en_ok = 0; ovp_flt = 1;
        #1;
        chk("R11 priority drv", drv_en, 0);
        edges(1);
        chk("R11 priority sr", sr_ramp, 0);
        chk("R11 priority ss", ss_ramp, 0);
        ovp_flt = 0; en_ok = 1;
        edges(400);
        ref_ok = 0;
        #1;
        chk("R8 ref low drv", drv_en, 0);
        edges(1);
        chk("R8 ref low ss", ss_ramp, 0);
        ref_ok = 1;

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule